// File: doc/BRIEF.md
# EEPROM Status and Write-Protection Unit

This block keeps the status byte of a serial EEPROM and decides whether each write request the command decoder hands it may go ahead. It tracks a busy flag for the self-timed write cycle, a write-enable latch that software must set before every write, a two-bit protection field that fences off the top part of the array, and a sticky lock bit. The lock bit works together with an active-low write-protect pin: while both are asserted the protection settings cannot be changed.

Commands arrive as one-cycle strobes from a decoder. Array writes carry a target address. Status writes carry a data byte. The unit answers with one-cycle start pulses for the array write engine or for the status write. These pulses come only when the request passes every check. A `cycle_done` pulse from the write engine ends the busy period. A status read strobe returns a snapshot of the status byte one cycle later. All control pins are plain level or pulse signals, with no handshake, because the decoder issues at most one strobe per cycle and never stalls.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte is 00h and `arr_start`, `sr_start` and `rd_valid` are low.
- R2: The status byte has busy in bit 0, write-enable in bit 1, the protection field in bits 3:2 and the lock bit in bit 7; bits 6:4 read 0. A `cmd_rdsr` strobe gives `rd_valid` high in the next cycle, with `rd_data` equal to the status byte from the cycle of the strobe.
- R3: `cmd_wren` sets the write-enable bit and `cmd_wrdi` clears it.
- R4: An accepted status write loads the lock bit from data bit 7 and the protection field from data bits 3:2, ignores the other data bits, pulses `sr_start` for one cycle and sets busy.
- R5: While the lock bit is 1 and `wp_n` is low, a status write is dropped. No pulse is given, the lock bit and the protection field keep their values, and write-enable stays set.
- R6: While the lock bit is 0, a status write with write-enable set is accepted whatever the level of `wp_n`. With `wp_n` high it is accepted even when the lock bit is 1.
- R7: An array write or status write made while write-enable is clear is dropped without a start pulse.
- R8: The protection field encodes 00 as no protection, 01 as the top quarter of the address space, 10 as the top half, and 11 as the whole array. An array write to an unprotected address with write-enable set pulses `arr_start` and sets busy.
- R9: An array write to a protected address is dropped. No pulse is given, busy stays 0, and write-enable stays set.
- R10: While busy, every command except status read is ignored. A `cycle_done` pulse while busy clears both busy and write-enable.
- R11: A `cycle_done` pulse while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wren | input | 1 | Strobe: set write-enable |
| cmd_wrdi | input | 1 | Strobe: clear write-enable |
| cmd_rdsr | input | 1 | Strobe: read status byte |
| cmd_wrsr | input | 1 | Strobe: write status byte |
| cmd_write | input | 1 | Strobe: array write request |
| wr_data | input | 8 | Data byte for a status write |
| wr_addr | input | ADDR_W | Target address of an array write |
| wp_n | input | 1 | Write-protect pin, active low |
| cycle_done | input | 1 | Pulse: write cycle has finished |
| status_byte | output | 8 | Live status byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a status snapshot |
| rd_data | output | 8 | Status snapshot from a read |
| arr_start | output | 1 | Pulse: start the array write cycle |
| sr_start | output | 1 | Pulse: start the status write cycle |

## Verification
A wrong bit inside the unit never stays hidden. Every register reaches `status_byte`, so a mismatch shows at the ports on the clock edge after the faulty update. A wrong protection decision shows in the same cycle as a missing or extra `arr_start` pulse, and a wrongly held busy flag or write-enable bit shows as a dropped or extra start pulse on the next request. The bench therefore compares every output with a behavioural model on every clock. On top of that, it walks through directed sequences at the edges of each protected range and through the lock combinations.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic       lock;
    logic [1:0] prot;
    logic       wel;
    logic       busy;
  } sg_state_t;

  function automatic logic [STAT_W-1:0] sg_pack(input sg_state_t s);
    return {s.lock, 3'b000, s.prot, s.wel, s.busy};
  endfunction
endpackage

// File: rtl/sg_range_guard.sv
module sg_range_guard #(
  parameter int ADDR_W = 15
) (
  input  logic [1:0]        prot,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;
  logic [1:0] upper;

  assign upper = addr[TOP -: 2];

  always_comb begin
    unique case (prot)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (upper == 2'b11);
      2'b10:   hit = upper[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_status_core.sv
module sg_status_core
  import sg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_wren,
  input  logic      cmd_wrdi,
  input  logic      cmd_wrsr,
  input  logic      cmd_write,
  input  logic [7:0] wr_data,
  input  logic      wp_n,
  input  logic      prot_hit,
  input  logic      cycle_done,
  output sg_state_t st_q,
  output logic      arr_start,
  output logic      sr_start
);
  logic locked;
  logic sr_ok;
  logic arr_ok;

  assign locked = st_q.lock & ~wp_n;
  assign sr_ok  = st_q.wel & ~locked;
  assign arr_ok = st_q.wel & ~prot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      arr_start <= 1'b0;
      sr_start  <= 1'b0;
    end else begin
      arr_start <= 1'b0;
      sr_start  <= 1'b0;
      if (st_q.busy) begin
        if (cycle_done) begin
          st_q.busy <= 1'b0;
          st_q.wel  <= 1'b0;
        end
      end else if (cmd_wrsr) begin
        if (sr_ok) begin
          st_q.lock <= wr_data[7];
          st_q.prot <= wr_data[3:2];
          st_q.busy <= 1'b1;
          sr_start  <= 1'b1;
        end
      end else if (cmd_write) begin
        if (arr_ok) begin
          st_q.busy <= 1'b1;
          arr_start <= 1'b1;
        end
      end else if (cmd_wren) begin
        st_q.wel <= 1'b1;
      end else if (cmd_wrdi) begin
        st_q.wel <= 1'b0;
      end
    end
  end

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.busy && cycle_done |=> !st_q.busy && !st_q.wel); // R10
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.busy && cmd_wrsr && st_q.lock && !wp_n |=> !sr_start && $stable(st_q.prot) && st_q.lock); // R5
  AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.busy && cmd_write && !cmd_wrsr && prot_hit |=> !arr_start && !st_q.busy && $stable(st_q.wel)); // R9
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.busy |=> !arr_start && !sr_start); // R10
  AST_NO_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q.wel |=> !arr_start && !sr_start); // R7
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_start, sr_start})); // R4
endmodule

// File: rtl/sg_read_port.sv
module sg_read_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_rdsr,
  input  logic [W-1:0] cur,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_rdsr;
      if (cmd_rdsr) rd_data <= cur;
    end
  end

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdsr |=> rd_valid && rd_data == $past(cur)); // R2
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_rdsr,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_n,
  input  logic              cycle_done,
  output logic [7:0]        status_byte,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              arr_start,
  output logic              sr_start
);
  sg_state_t st;
  logic      hit;

  sg_range_guard #(.ADDR_W(ADDR_W)) u_guard (
    .prot (st.prot),
    .addr (wr_addr),
    .hit  (hit)
  );

  sg_status_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_write  (cmd_write),
    .wr_data    (wr_data),
    .wp_n       (wp_n),
    .prot_hit   (hit),
    .cycle_done (cycle_done),
    .st_q       (st),
    .arr_start  (arr_start),
    .sr_start   (sr_start)
  );

  assign status_byte = sg_pack(st);

  sg_read_port #(.W(STAT_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_rdsr (cmd_rdsr),
    .cur      (status_byte),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !st.busy && cycle_done && !cmd_wren && !cmd_wrdi && !cmd_wrsr && !cmd_write
      |=> $stable(status_byte)); // R11
endmodule

// File: tb/eeprom_status_guard_tb.sv
module eeprom_status_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic wp_n = 1'b1;
  logic cycle_done = 1'b0;
  logic [7:0] status_byte, rd_data;
  logic rd_valid, arr_start, sr_start;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;
  logic last_arr, last_sr;

  // behavioural model
  int m_lock, m_prot, m_wel, m_busy, m_arr, m_sr, m_rdv, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_status_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_rdsr(cmd_rdsr), .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write),
    .wr_data(wr_data), .wr_addr(wr_addr), .wp_n(wp_n), .cycle_done(cycle_done),
    .status_byte(status_byte), .rd_valid(rd_valid), .rd_data(rd_data),
    .arr_start(arr_start), .sr_start(sr_start));

  function automatic int m_status();
    return m_lock * 128 + m_prot * 4 + m_wel * 2 + m_busy;
  endfunction

  function automatic bit m_protected(int a);
    int lim;
    case (m_prot)
      0: lim = SIZE;
      1: lim = (SIZE / 4) * 3;
      2: lim = SIZE / 2;
      default: lim = 0;
    endcase
    return a >= lim;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_prot = 0; m_wel = 0; m_busy = 0;
      m_arr = 0; m_sr = 0; m_rdv = 0; m_rd = 0;
    end else begin
      m_arr = 0; m_sr = 0; m_rdv = 0;
      if (cmd_rdsr) begin m_rdv = 1; m_rd = m_status(); end
      if (m_busy != 0) begin
        if (cycle_done) begin m_busy = 0; m_wel = 0; end
      end else if (cmd_wrsr) begin
        if (m_wel != 0 && !(m_lock != 0 && !wp_n)) begin
          m_lock = wr_data[7]; m_prot = wr_data[3:2]; m_busy = 1; m_sr = 1;
        end
      end else if (cmd_write) begin
        if (m_wel != 0 && !m_protected(int'(wr_addr))) begin m_busy = 1; m_arr = 1; end
      end else if (cmd_wren) m_wel = 1;
      else if (cmd_wrdi) m_wel = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 status_byte vs model", status_byte, m_status());
      chk("R8 arr_start vs model", arr_start, m_arr);
      chk("R4 sr_start vs model", sr_start, m_sr);
      chk("R2 rd_valid vs model", rd_valid, m_rdv);
      if (m_rdv != 0) chk("R2 rd_data vs model", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // kinds: 0 wren 1 wrdi 2 rdsr 3 wrsr 4 write 5 done
  task automatic op(input int kind, input logic [7:0] d = 8'h00, input int a = 0);
    @(negedge clk);
    wr_data = d; wr_addr = a[AW-1:0];
    cmd_wren = (kind == 0); cmd_wrdi = (kind == 1); cmd_rdsr = (kind == 2);
    cmd_wrsr = (kind == 3); cmd_write = (kind == 4); cycle_done = (kind == 5);
    @(posedge clk); #1;
    last_arr = arr_start; last_sr = sr_start;
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0; cmd_wrsr = 0; cmd_write = 0; cycle_done = 0;
  endtask

  task automatic set_prot(input logic [7:0] d);
    op(0); op(3, d); op(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_byte, 0);
    chk("R1 reset starts", {arr_start, sr_start, rd_valid}, 0);
    rst_n = 1'b1;

    op(4, 8'h00, 0);
    chk("R7 write without enable", last_arr, 0);
    op(3, 8'h8C);
    chk("R7 status write without enable", last_sr, 0);
    chk("R7 status unchanged", status_byte, 8'h00);
    op(0);
    chk("R3 wren sets", status_byte, 8'h02);
    op(1);
    chk("R3 wrdi clears", status_byte, 8'h00);

    op(0); op(4, 8'h00, 16'h7FFF);
    chk("R8 unprotected write starts", last_arr, 1);
    chk("R10 busy set", status_byte, 8'h03);
    op(4, 8'h00, 0);
    chk("R10 write ignored while busy", last_arr, 0);
    op(1);
    chk("R10 wrdi ignored while busy", status_byte, 8'h03);
    op(2);
    @(negedge clk);
    op(5);
    chk("R10 done clears busy and enable", status_byte, 8'h00);
    op(5);
    chk("R11 idle done no effect", status_byte, 8'h00);

    wp_n = 1'b0;
    op(0); op(3, 8'hFF);
    chk("R6 unlocked write with pin low", last_sr, 1);
    chk("R4 only lock and field loaded", status_byte, 8'h8F);
    op(5);
    chk("R4 after done", status_byte, 8'h8C);
    op(0); op(3, 8'h00);
    chk("R5 locked write dropped", last_sr, 0);
    chk("R5 status kept, enable stays", status_byte, 8'h8E);
    wp_n = 1'b1;
    op(3, 8'h04);
    chk("R6 pin high unlocks", last_sr, 1);
    op(5);
    chk("R4 field quarter", status_byte, 8'h04);

    op(0); op(4, 8'h00, 16'h5FFF);
    chk("R8 quarter below edge", last_arr, 1);
    op(5); op(0); op(4, 8'h00, 16'h6000);
    chk("R9 quarter edge dropped", last_arr, 0);
    chk("R9 enable stays, not busy", status_byte, 8'h06);

    op(3, 8'h08); op(5);
    op(0); op(4, 8'h00, 16'h3FFF);
    chk("R8 half below edge", last_arr, 1);
    op(5); op(0); op(4, 8'h00, 16'h4000);
    chk("R9 half edge dropped", last_arr, 0);

    op(3, 8'h0C); op(5);
    op(0); op(4, 8'h00, 0);
    chk("R9 whole array dropped", last_arr, 0);
    op(3, 8'h00); op(5);

    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      wp_n = $urandom_range(0, 1);
      op(r > 5 ? 5 : r, 8'($urandom), int'($urandom_range(0, SIZE - 1)));
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule